// File: doc/BRIEF.md
# Oversampled Encoder Phase Comparator

This block measures how far a quadrature-encoded motor shaft has drifted from a crystal-timed reference, and it does so many times per revolution instead of once. A strobe derived from the crystal clock, `sample_tick`, arrives at K times the wanted rotation rate. Between two strobes the shaft should advance by N/K encoder counts, where N is the number of counts in one revolution. On each strobe the block subtracts that expected advance from the counts it actually saw and reports the signed difference. It also adds the difference into a running position error that a loop filter downstream can use.

The encoder lines are asynchronous. They pass through a flop synchronizer and then a 4x quadrature decoder, which yields one signed count for every valid edge. Encoder edges never serve as the time base: windows are opened and closed only by the strobe. When N is not a multiple of K, a remainder accumulator spreads the extra counts over the strobes, so K strobes always expect exactly N counts in total. K should stay well below N. One count of position uncertainty weighs more heavily in a short window.

Top module: `enc_phase_comparator`

## Requirements
- R1: While `rst_n` is low, `err_sample` and `err_accum` are zero and `err_valid` is low.
- R2: The encoder inputs pass through SYNC_STAGES flops, and one more flop holds the previous state. An input change sampled at clock edge t is counted at edge t+SYNC_STAGES.
- R3: The pair {A,B} is decoded 4x. The sequence 00→10→11→01→00 (A leads B) counts +1 per transition, and the reverse sequence counts −1.
- R4: A transition in which both A and B change, or in which neither changes, adds nothing to the count.
- R5: At each clock edge where `sample_tick` is high, the window count is formed from the counts since the previous strobe plus any count resolved at that edge. The window count minus the expected advance appears on `err_sample` one cycle later, with `err_valid` high for that one cycle. The window then restarts from zero.
- R6: The expected advance is floor(N/K), plus one on the strobes where a remainder accumulator (adding N mod K, wrapping at K) carries. For the i-th strobe since reset it equals floor(i·N/K) − floor((i−1)·N/K).
- R7: `err_sample` holds its value between strobes.
- R8: At each strobe `err_accum` takes its previous value plus the new `err_sample`, and it holds between strobes.
- R9: `err_sample` saturates to the signed ERR_W range. The window count saturates at a range four times that size.
- R10: `err_accum` saturates to the signed ERR_W range rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| sample_tick | input | 1 | One-cycle strobe at K times the wanted rotation rate |
| err_valid | output | 1 | High for one cycle after each strobe |
| err_sample | output | ERR_W | Signed per-window error in encoder counts |
| err_accum | output | ERR_W | Signed saturating sum of the window errors |

## Verification
The bench builds the block with N = 100, K = 16 and ERR_W = 8. With these values the remainder is 4, so every fourth strobe expects 7 counts instead of 6, and the carry pattern repeats within a short run. The 8-bit range puts saturation of both the window error and the accumulated error within a few hundred encoder edges, or a few dozen idle strobes. Back-to-back strobes, counts that coincide with a strobe, reverse motion and two-bit jumps are all driven against a behavioural model.

// File: rtl/enc_phase_pkg.sv
package enc_phase_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DOWN = 2'b11
    } step_t;

    function automatic int step_val(input step_t s);
        case (s)
            STEP_UP:   return 1;
            STEP_DOWN: return -1;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ab_in,
    output logic [1:0] ab_sync
);
    logic [1:0] stg_q [STAGES];
    logic [1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = ab_in;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign ab_sync = stg_q[STAGES-1];
endmodule

// File: rtl/quad_decode.sv
module quad_decode
    import enc_phase_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ab_cur,
    output step_t      step
);
    logic [1:0] prev_q, prev_d;

    always_comb begin
        prev_d = ab_cur;
        case ({prev_q, ab_cur})
            4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: step = STEP_UP;
            4'b00_01, 4'b01_11, 4'b11_10, 4'b10_00: step = STEP_DOWN;
            default:                                step = STEP_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    AST_STEP_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (step != STEP_NONE) |-> ($countones(prev_q ^ ab_cur) == 1)); // R4
endmodule

// File: rtl/expect_gen.sv
module expect_gen #(
    parameter int COUNTS_PER_REV  = 1000,
    parameter int SAMPLES_PER_REV = 16,
    parameter int EXP_W           = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [EXP_W-1:0] exp_cnt
);
    localparam int BASE = COUNTS_PER_REV / SAMPLES_PER_REV;
    localparam int REM  = COUNTS_PER_REV % SAMPLES_PER_REV;
    localparam int FW   = $clog2(SAMPLES_PER_REV) + 1;

    generate
        if (REM == 0) begin : g_exact
            assign exp_cnt = EXP_W'(BASE);
        end else begin : g_frac
            logic [FW-1:0] frac_q, frac_d;
            logic          carry;

            always_comb begin
                carry   = (int'(frac_q) + REM) >= SAMPLES_PER_REV;
                exp_cnt = EXP_W'(BASE + (carry ? 1 : 0));
                frac_d  = frac_q;
                if (advance) begin
                    frac_d = carry ? FW'(int'(frac_q) + REM - SAMPLES_PER_REV)
                                   : FW'(int'(frac_q) + REM);
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) frac_q <= '0;
                else        frac_q <= frac_d;
            end

            AST_FRAC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                int'(frac_q) < SAMPLES_PER_REV); // R6
        end
    endgenerate
endmodule

// File: rtl/enc_phase_comparator.sv
module enc_phase_comparator
    import enc_phase_pkg::*;
#(
    parameter int COUNTS_PER_REV  = 1000,
    parameter int SAMPLES_PER_REV = 16,
    parameter int ERR_W           = 16,
    parameter int SYNC_STAGES     = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enc_a,
    input  logic                    enc_b,
    input  logic                    sample_tick,
    output logic                    err_valid,
    output logic signed [ERR_W-1:0] err_sample,
    output logic signed [ERR_W-1:0] err_accum
);
    localparam int WIN_W   = ERR_W + 2;
    localparam int WIN_MAX = 2 ** (WIN_W - 1) - 1;
    localparam int WIN_MIN = -(2 ** (WIN_W - 1));
    localparam int ERR_MAX = 2 ** (ERR_W - 1) - 1;
    localparam int ERR_MIN = -(2 ** (ERR_W - 1));
    localparam int EXP_W   = $clog2(COUNTS_PER_REV / SAMPLES_PER_REV + 2) + 1;

    typedef struct packed {
        logic signed [WIN_W-1:0] win;
        logic signed [ERR_W-1:0] err;
        logic signed [ERR_W-1:0] acc;
        logic                    valid;
    } cmp_state_t;

    function automatic logic signed [ERR_W-1:0] sat_err(input logic signed [31:0] v);
        if (v > ERR_MAX)      return ERR_W'(ERR_MAX);
        else if (v < ERR_MIN) return ERR_W'(ERR_MIN);
        else                  return ERR_W'(v);
    endfunction

    function automatic logic signed [WIN_W-1:0] sat_win(input logic signed [31:0] v);
        if (v > WIN_MAX)      return WIN_W'(WIN_MAX);
        else if (v < WIN_MIN) return WIN_W'(WIN_MIN);
        else                  return WIN_W'(v);
    endfunction

    logic [1:0]              ab_sync;
    step_t                   step;
    logic [EXP_W-1:0]        exp_cnt;
    logic signed [31:0]      win_sum;
    logic signed [ERR_W-1:0] err_new;
    cmp_state_t              st_q, st_d;

    enc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ab_in   ({enc_a, enc_b}),
        .ab_sync (ab_sync)
    );

    quad_decode u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .ab_cur (ab_sync),
        .step   (step)
    );

    expect_gen #(
        .COUNTS_PER_REV  (COUNTS_PER_REV),
        .SAMPLES_PER_REV (SAMPLES_PER_REV),
        .EXP_W           (EXP_W)
    ) u_exp (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (sample_tick),
        .exp_cnt (exp_cnt)
    );

    always_comb begin
        st_d    = st_q;
        win_sum = 32'(st_q.win) + step_val(step);
        err_new = sat_err(win_sum - int'(exp_cnt));
        if (sample_tick) begin
            st_d.err   = err_new;
            st_d.acc   = sat_err(32'(st_q.acc) + 32'(err_new));
            st_d.win   = '0;
            st_d.valid = 1'b1;
        end else begin
            st_d.win   = sat_win(win_sum);
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_valid  = st_q.valid;
    assign err_sample = st_q.err;
    assign err_accum  = st_q.acc;

    AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |=> err_valid); // R5
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_tick |=> $stable(err_sample)); // R7
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_tick |=> $stable(err_accum)); // R8
    AST_ACC_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && err_accum == ERR_W'(ERR_MAX) && err_new >= 0)
        |=> (err_accum == ERR_W'(ERR_MAX))); // R10
    AST_ACC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && err_accum == ERR_W'(ERR_MIN) && err_new <= 0)
        |=> (err_accum == ERR_W'(ERR_MIN))); // R10
endmodule

// File: tb/tb_enc_phase_comparator.sv
module tb_enc_phase_comparator;
    localparam int N     = 100;
    localparam int K     = 16;
    localparam int EW    = 8;
    localparam int EMAX  = 2 ** (EW - 1) - 1;
    localparam int EMIN  = -(2 ** (EW - 1));
    localparam int WMAX  = 2 ** (EW + 1) - 1;
    localparam int WMIN  = -(2 ** (EW + 1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enc_a = 1'b0, enc_b = 1'b0, sample_tick = 1'b0;
    logic err_valid;
    logic signed [EW-1:0] err_sample, err_accum;

    always #4 clk = ~clk;

    enc_phase_comparator #(
        .COUNTS_PER_REV(N), .SAMPLES_PER_REV(K), .ERR_W(EW), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .sample_tick(sample_tick), .err_valid(err_valid),
        .err_sample(err_sample), .err_accum(err_accum)
    );

    int compared = 0, mismatched = 0;
    bit done = 0;
    string phase_req = "R1";

    // behavioural reference
    logic [1:0] smp_ab;
    logic       smp_tick;
    logic [1:0] h1 = 2'b00, h2 = 2'b00, hprev = 2'b00;
    int m_win = 0, m_err = 0, m_acc = 0, m_ticks = 0;
    bit m_valid = 0;

    function automatic int pos_of(input logic [1:0] ab);
        case (ab)
            2'b00: return 0;
            2'b10: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int clampi(input int v, input int lo, input int hi);
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    always @(posedge clk) begin
        smp_ab   <= {enc_a, enc_b};
        smp_tick <= sample_tick;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            h1 = 0; h2 = 0; hprev = 0;
            m_win = 0; m_err = 0; m_acc = 0; m_ticks = 0; m_valid = 0;
        end else begin
            int d, st, idx, ex, tot;
            d  = (pos_of(h2) - pos_of(hprev) + 4) % 4;
            st = (d == 1) ? 1 : ((d == 3) ? -1 : 0);
            if (smp_tick) begin
                idx = m_ticks % K + 1;
                ex  = (idx * N) / K - ((idx - 1) * N) / K;
                m_ticks = idx % K;
                tot = m_win + st;
                m_err = clampi(tot - ex, EMIN, EMAX);
                m_acc = clampi(m_acc + m_err, EMIN, EMAX);
                m_win = 0;
                m_valid = 1;
            end else begin
                m_win = clampi(m_win + st, WMIN, WMAX);
                m_valid = 0;
            end
            hprev = h2; h2 = h1; h1 = smp_ab;
        end
        check({phase_req, " R5"}, "err_valid", int'(err_valid), int'(m_valid));
        check({phase_req, " R5/R7/R9"}, "err_sample", int'(err_sample), m_err);
        check({phase_req, " R8/R10"}, "err_accum", int'(err_accum), m_acc);
    end

    // stimulus
    int ph = 0;
    task automatic drive(input int kind, input bit tk);
        @(posedge clk); #1;
        case (kind)
            1: ph = (ph + 1) % 4;
            2: ph = (ph + 3) % 4;
            3: ph = (ph + 2) % 4;
            default: ;
        endcase
        case (ph)
            0: {enc_a, enc_b} = 2'b00;
            1: {enc_a, enc_b} = 2'b10;
            2: {enc_a, enc_b} = 2'b11;
            default: {enc_a, enc_b} = 2'b01;
        endcase
        sample_tick = tk;
    endtask

    task automatic window(input int cycles, input int kind, input int every);
        for (int c = 0; c < cycles; c++) drive((every > 0 && c % every == 0) ? kind : 0, 1'b0);
        drive(0, 1'b1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        // R1: outputs cleared in reset
        @(negedge clk);
        check("R1", "reset err_valid", int'(err_valid), 0);
        check("R1", "reset err_sample", int'(err_sample), 0);
        check("R1", "reset err_accum", int'(err_accum), 0);
        @(posedge clk); #1; rst_n = 1'b1;
        phase_req = "R6";
        for (int i = 0; i < 6; i++) window(10, 0, 0);          // idle: -6/-7 carry pattern
        phase_req = "R2/R3";
        for (int i = 0; i < 20; i++) window(20, 1, 3);         // forward near rate
        phase_req = "R3";
        for (int i = 0; i < 4; i++) window(24, 2, 2);          // reverse motion
        phase_req = "R4";
        for (int i = 0; i < 3; i++) window(12, 3, 2);          // two-bit jumps ignored
        for (int i = 0; i < 2; i++) window(9, 0, 0);
        phase_req = "R5";
        for (int i = 0; i < 6; i++) drive(1, 1'b1);            // steps on back-to-back ticks
        drive(1, 1'b0); drive(0, 1'b0); drive(0, 1'b1);        // step resolving on tick edge
        drive(0, 1'b0); drive(0, 1'b1);
        phase_req = "R9";
        window(300, 1, 1);                                     // positive saturation
        phase_req = "R10";
        for (int i = 0; i < 3; i++) window(200, 1, 1);
        phase_req = "R9";
        window(300, 2, 1);                                     // negative saturation
        phase_req = "R10";
        for (int i = 0; i < 60; i++) window(1, 0, 0);          // drive accum to floor
        phase_req = "R7";
        window(15, 1, 4);
        repeat (8) drive(0, 1'b0);
        @(negedge clk); @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule